// File: doc/BRIEF.md
# Asynchronous Serial Channel with Programmable Prescaler

This block is a full-duplex asynchronous serial channel reached through a small 8-bit register window. Software sets the character format, the sampling rate and the enables in two control registers. It loads characters into a transmit holding register and collects received characters from a single receive holding register. A status register reports data-full, data-empty and error conditions, and holds the two interrupt enables.

The sampling clock runs at 16 or 64 times the bit rate. It comes from the system clock through a prescaler of 10 or 30 followed by a power-of-two stage of 1 to 64. A reserved speed code instead counts edges of an external clock pin. An optional multiprocessor bit can follow the data bits. When multiprocessor mode is on, the receiver uses that bit to ignore traffic that is not addressed to it.

Top module: `async_serial_chan`

Register map (`addr`): 0 = control A, 1 = control B, 2 = status, 3 = transmit data (write), 4 = receive data (read; a read with `rd_en` high consumes it). Other addresses read 0.

## Requirements
- R1: Control A bits [2:0] select the frame. Bit 2 = 8 data bits (else 7), bit 1 = parity bit present, bit 0 = two stop bits (else one). On the line the frame is sent as: a start bit of 0, the data LSB first, the multiprocessor bit (when control A bit 7 is set), the parity bit, then the stop bits at 1. The line idles at 1.
- R2: One bit lasts P x S x 2^SS system clock cycles. P is 10, or 30 when control B bit 5 is set. S is 16, or 64 when control B bit 3 is set. SS is control B bits [2:0], with values 0..6.
- R3: With SS = 7, each rising edge of `ext_clk` counts as one sampling tick, so one bit lasts S edges.
- R4: With parity on, the parity bit gives the data plus parity bit an even number of ones when control B bit 4 is 0, and an odd number when it is 1.
- R5: Writing address 3 clears the transmit-empty flag (status bit 1). A frame starts only while control A bit 5 (transmit enable) is 1 and `cts_n` is 0. The flag returns to 1 when the character moves into the shifter.
- R6: A received frame sets receive-full (status bit 7) and makes the data readable at address 4; a 7-bit character reads with bit 7 = 0. A read of address 4 with `rd_en` clears receive-full. A bad parity bit sets status bit 5. A first stop bit of 0 sets status bit 4.
- R7: When a frame completes while receive-full is set, status bit 6 (overrun) is set and the new character is dropped.
- R8: Writing control A with bit 3 = 0 clears status bits 6, 5 and 4. Receive-full is left unchanged.
- R9: With control A bit 7 set, the transmitter sends control B bit 7 as the multiprocessor bit. A received frame whose multiprocessor bit is 0 is discarded and changes no flag. The bit received with the last accepted frame reads back in control A bit 3.
- R10: A start bit that is no longer low at mid-bit is treated as a glitch and produces no character.
- R11: `rx_irq` = status bit 3 AND (receive-full OR any error flag). `tx_irq` = status bit 0 AND transmit-empty.
- R12: `rts_n` equals control A bit 4. Status bit 2 reads the `dcd_n` level. The receiver starts frames only while `dcd_n` is 0 and control A bit 6 is 1.
- R13: After reset, control A reads 0x10, control B reads 0x00, status reads 0x02 with `dcd_n` = 0, `txd` is 1, and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe; consumes receive data at address 4 |
| rdata | output | 8 | Read data for `addr` (combinational) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts_n | output | 1 | Request-to-send output |
| cts_n | input | 1 | Clear-to-send input, low allows transmission |
| dcd_n | input | 1 | Carrier-detect input, low allows reception |
| ext_clk | input | 1 | External sampling clock, used when SS = 7 |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The bench runs all eight frame formats through both the transmitter and the receiver. It also measures bit time on the line under both prescalers, both sampling ratios and the external clock, so a divider that drops the power-of-two stage or swaps ratios shows up as a wrong pulse width. Directed cases target the receive edge conditions. A second character arriving while the first is unread must leave the first intact. A short low pulse must not become a character. Frames whose multiprocessor bit is 0 must vanish without setting flags. The error-clear write must touch only the error flags. The transmitter is held off by `cts_n`, and the receiver is held off by `dcd_n`; a design that ignored either would send or accept a frame it should not.

// File: rtl/asc_pkg.sv
package asc_pkg;
   localparam int REG_W   = 8;
   localparam int ADDR_W  = 3;
   localparam int FRAME_W = 13;   // start + 8 data + mp + parity + 2 stop
   localparam int RBUF_W  = 11;   // 8 data + mp + parity + 1 stop

   localparam logic [ADDR_W-1:0] A_CTLA = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTLB = 3'd1;
   localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
   localparam logic [ADDR_W-1:0] A_TXD  = 3'd3;
   localparam logic [ADDR_W-1:0] A_RXD  = 3'd4;

   typedef struct packed {
      logic dbits8;
      logic parity;
      logic stop2;
   } fmt_t;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_st_t;
endpackage

// File: rtl/asc_baud.sv
module asc_baud #(
   parameter int PRE_LO = 10,
   parameter int PRE_HI = 30,
   parameter int SYNC   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pre_sel,
   input  logic [2:0] ss,
   input  logic       ext_clk,
   output logic       tick
);
   localparam int DIV_W = $clog2(PRE_HI) + 8;

   logic [DIV_W-1:0] cnt, base, limit;
   logic [SYNC:0]    ext_sh;
   logic             use_ext, int_tick, ext_rise;

   assign use_ext  = (ss == 3'd7);
   assign base     = pre_sel ? DIV_W'(PRE_HI) : DIV_W'(PRE_LO);
   assign limit    = base << ss;
   assign int_tick = !use_ext && (cnt >= limit - 1'b1);
   assign ext_rise = ext_sh[SYNC-1] && !ext_sh[SYNC];
   assign tick     = use_ext ? ext_rise : int_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         ext_sh <= '0;
      end else begin
         ext_sh <= {ext_sh[SYNC-1:0], ext_clk};
         if (use_ext || int_tick) cnt <= '0;
         else                     cnt <= cnt + 1'b1;
      end
   end

   // R2/R3: the sampling tick is never high in two cycles in a row
   a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/asc_tx.sv
module asc_tx
   import asc_pkg::*;
#(
   parameter int OVS_LO = 16,
   parameter int OVS_HI = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       ovs_sel,
   input  logic       tx_en,
   input  logic       cts_n,
   input  logic       tdr_full,
   input  logic [7:0] tdr,
   input  fmt_t       fmt,
   input  logic       mp_en,
   input  logic       mp_bit,
   input  logic       par_odd,
   output logic       take,
   output logic       txd
);
   localparam int CNT_W = $clog2(OVS_HI);

   logic [FRAME_W-1:0] frame, sh;
   logic [3:0]         nb, left;
   logic [CNT_W-1:0]   cnt, last;
   logic [7:0]         dmask;
   logic               busy;

   assign last  = ovs_sel ? CNT_W'(OVS_HI-1) : CNT_W'(OVS_LO-1);
   assign dmask = fmt.dbits8 ? tdr : {1'b0, tdr[6:0]};

   // Build the whole frame, LSB goes out first
   always_comb begin
      logic [3:0] pos;
      frame    = '1;
      frame[0] = 1'b0;
      pos      = 4'd1;
      for (int i = 0; i < 8; i++) begin
         if (i < 7 || fmt.dbits8) begin
            frame[pos] = tdr[i];
            pos = pos + 4'd1;
         end
      end
      if (mp_en) begin
         frame[pos] = mp_bit;
         pos = pos + 4'd1;
      end
      if (fmt.parity) begin
         frame[pos] = (^dmask) ^ par_odd;
         pos = pos + 4'd1;
      end
      nb = pos + (fmt.stop2 ? 4'd2 : 4'd1);
   end

   assign take = tick && !busy && tdr_full && tx_en && !cts_n;
   assign txd  = busy ? sh[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         sh   <= '1;
         left <= '0;
         cnt  <= '0;
      end else if (take) begin
         busy <= 1'b1;
         sh   <= frame;
         left <= nb;
         cnt  <= '0;
      end else if (busy && tick) begin
         if (cnt == last) begin
            cnt <= '0;
            if (left == 4'd1) busy <= 1'b0;
            else begin
               sh   <= {1'b1, sh[FRAME_W-1:1]};
               left <= left - 4'd1;
            end
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   // R1: every frame opens with a low start bit
   a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (txd == 1'b0));
   // R1: the line only moves on sampling ticks
   a_r1_line_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(txd));
endmodule

// File: rtl/asc_rx.sv
module asc_rx
   import asc_pkg::*;
#(
   parameter int OVS_LO = 16,
   parameter int OVS_HI = 64,
   parameter int SYNC   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       ovs_sel,
   input  logic       rx_en,
   input  logic       dcd_n,
   input  logic       rxd,
   input  fmt_t       fmt,
   input  logic       mp_en,
   input  logic       par_odd,
   output logic       done,
   output logic [7:0] data,
   output logic       mp,
   output logic       perr,
   output logic       ferr
);
   localparam int CNT_W = $clog2(OVS_HI);

   logic [SYNC-1:0]   sync_q;
   logic              rxd_s;
   rx_st_t            st;
   logic [CNT_W-1:0]  cnt, last, half;
   logic [3:0]        idx, db, par_pos, stop_pos;
   logic [RBUF_W-1:0] rbuf;

   genvar g;
   generate
      for (g = 0; g < SYNC; g++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= 1'b1;
            else        sync_q[g] <= (g == 0) ? rxd : sync_q[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate
   assign rxd_s = sync_q[SYNC-1];

   assign last     = ovs_sel ? CNT_W'(OVS_HI-1)   : CNT_W'(OVS_LO-1);
   assign half     = ovs_sel ? CNT_W'(OVS_HI/2-1) : CNT_W'(OVS_LO/2-1);
   assign db       = fmt.dbits8 ? 4'd8 : 4'd7;
   assign par_pos  = db + {3'd0, mp_en};
   assign stop_pos = par_pos + {3'd0, fmt.parity};

   assign data = fmt.dbits8 ? rbuf[7:0] : {1'b0, rbuf[6:0]};
   assign mp   = mp_en && rbuf[db];
   assign perr = fmt.parity && (rbuf[par_pos] != ((^data) ^ par_odd));
   assign ferr = !rbuf[stop_pos];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= RX_IDLE;
         cnt  <= '0;
         idx  <= '0;
         rbuf <= '1;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               RX_IDLE: if (rx_en && !dcd_n && !rxd_s) begin
                  st  <= RX_START;
                  cnt <= '0;
               end
               RX_START: if (cnt == half) begin
                  cnt <= '0;
                  idx <= '0;
                  st  <= rxd_s ? RX_IDLE : RX_DATA;   // high at mid-bit: glitch
               end else cnt <= cnt + 1'b1;
               RX_DATA: if (cnt == last) begin
                  cnt       <= '0;
                  rbuf[idx] <= rxd_s;
                  if (idx == stop_pos) begin
                     st   <= RX_IDLE;
                     done <= 1'b1;
                  end else idx <= idx + 4'd1;
               end else cnt <= cnt + 1'b1;
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

   // R6: a character completes only by leaving the data state
   a_r6_done_from_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(st) == RX_DATA));
endmodule

// File: rtl/async_serial_chan.sv
module async_serial_chan
   import asc_pkg::*;
#(
   parameter int PRE_LO      = 10,
   parameter int PRE_HI      = 30,
   parameter int OVS_LO      = 16,
   parameter int OVS_HI      = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] addr,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       rd_en,
   output logic [7:0] rdata,
   output logic       txd,
   input  logic       rxd,
   output logic       rts_n,
   input  logic       cts_n,
   input  logic       dcd_n,
   input  logic       ext_clk,
   output logic       rx_irq,
   output logic       tx_irq
);
   generate
      if (OVS_LO < 4 || OVS_HI < OVS_LO || (OVS_LO % 2) != 0)
         $error("sampling ratios must be even, at least 4 and ordered");
      if (PRE_LO < 2 || PRE_HI < PRE_LO)
         $error("prescale values must be at least 2 and ordered");
      if (SYNC_STAGES < 2)
         $error("at least two synchroniser stages are needed");
   endgenerate

   logic [4:0]       ctla_hi;     // mp_en, rx_en, tx_en, rts, (unused slot)
   logic [2:0]       mode;
   logic [REG_W-1:0] ctlb, tdr, rdr;
   logic             tdr_full, rx_full, ovr, pe, fe, rx_ie, tx_ie, mpr;
   logic             wr_a, wr_txd, wr_stat, rd_rxd, accept;
   logic             tick, tx_take, rx_done, rx_mp, rx_perr, rx_ferr;
   logic [7:0]       rx_data;
   fmt_t             fmt;

   logic mp_en, rx_en, tx_en;
   assign mp_en = ctla_hi[4];
   assign rx_en = ctla_hi[3];
   assign tx_en = ctla_hi[2];
   assign rts_n = ctla_hi[1];
   assign fmt   = fmt_t'(mode);

   assign wr_a    = wr_en && (addr == A_CTLA);
   assign wr_txd  = wr_en && (addr == A_TXD);
   assign wr_stat = wr_en && (addr == A_STAT);
   assign rd_rxd  = rd_en && (addr == A_RXD);
   assign accept  = rx_done && !(mp_en && !rx_mp);

   asc_baud #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .SYNC(SYNC_STAGES)) u_baud (
      .clk(clk), .rst_n(rst_n), .pre_sel(ctlb[5]), .ss(ctlb[2:0]),
      .ext_clk(ext_clk), .tick(tick));

   asc_tx #(.OVS_LO(OVS_LO), .OVS_HI(OVS_HI)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ovs_sel(ctlb[3]),
      .tx_en(tx_en), .cts_n(cts_n), .tdr_full(tdr_full), .tdr(tdr),
      .fmt(fmt), .mp_en(mp_en), .mp_bit(ctlb[7]), .par_odd(ctlb[4]),
      .take(tx_take), .txd(txd));

   asc_rx #(.OVS_LO(OVS_LO), .OVS_HI(OVS_HI), .SYNC(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ovs_sel(ctlb[3]),
      .rx_en(rx_en), .dcd_n(dcd_n), .rxd(rxd), .fmt(fmt), .mp_en(mp_en),
      .par_odd(ctlb[4]), .done(rx_done), .data(rx_data), .mp(rx_mp),
      .perr(rx_perr), .ferr(rx_ferr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctla_hi  <= 5'b00010;
         mode     <= '0;
         ctlb     <= '0;
         tdr      <= '0;
         tdr_full <= 1'b0;
         rdr      <= '0;
         rx_full  <= 1'b0;
         ovr      <= 1'b0;
         pe       <= 1'b0;
         fe       <= 1'b0;
         rx_ie    <= 1'b0;
         tx_ie    <= 1'b0;
         mpr      <= 1'b0;
      end else begin
         if (wr_a) begin
            ctla_hi <= {wdata[7:4], 1'b0};
            mode    <= wdata[2:0];
            if (!wdata[3]) begin
               ovr <= 1'b0;
               pe  <= 1'b0;
               fe  <= 1'b0;
            end
         end
         if (wr_en && addr == A_CTLB) ctlb <= wdata;
         if (wr_stat) begin
            rx_ie <= wdata[3];
            tx_ie <= wdata[0];
         end
         if (tx_take) tdr_full <= 1'b0;
         if (wr_txd) begin
            tdr      <= wdata;
            tdr_full <= 1'b1;
         end
         if (rd_rxd) rx_full <= 1'b0;
         if (accept) begin
            if (rx_full && !rd_rxd) ovr <= 1'b1;
            else begin
               rdr     <= rx_data;
               rx_full <= 1'b1;
               mpr     <= rx_mp;
               if (rx_perr) pe <= 1'b1;
               if (rx_ferr) fe <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      case (addr)
         A_CTLA:  rdata = {ctla_hi[4:1], mpr, mode};
         A_CTLB:  rdata = ctlb;
         A_STAT:  rdata = {rx_full, ovr, pe, fe, rx_ie, dcd_n, !tdr_full, tx_ie};
         A_RXD:   rdata = rdr;
         default: rdata = '0;
      endcase
   end

   assign rx_irq = rx_ie && (rx_full || ovr || pe || fe);
   assign tx_irq = tx_ie && !tdr_full;

   // R7: an overrun keeps the held character and raises the flag
   a_r7_overrun_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && rx_full && !rd_rxd) |=> (ovr && $stable(rdr)));
   // R8: the error-clear write empties the error flags
   a_r8_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_a && !wdata[3] && !rx_done) |=> !(ovr || pe || fe));
   // R9: a frame with multiprocessor bit 0 changes nothing
   a_r9_mp_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && mp_en && !rx_mp && !rd_rxd) |=> ($stable(rx_full) && $stable(rdr)));
   // R5: a character taken by the shifter empties the holding register
   a_r5_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_take && !wr_txd) |=> !tdr_full);
endmodule

// File: tb/tb_async_serial_chan.sv
module tb_async_serial_chan;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0, rdata;
   logic       txd, rxd = 1'b1, rts_n, cts_n = 1'b0, dcd_n = 1'b0, ext_clk = 1'b0;
   logic       rx_irq, tx_irq;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;
   initial forever begin
      repeat (50) @(posedge clk);
      ext_clk = ~ext_clk;
   end

   async_serial_chan dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
      .rd_en(rd_en), .rdata(rdata), .txd(txd), .rxd(rxd), .rts_n(rts_n),
      .cts_n(cts_n), .dcd_n(dcd_n), .ext_clk(ext_clk), .rx_irq(rx_irq),
      .tx_irq(tx_irq));

   // mode[2:0], parity odd, data
   localparam logic [11:0] VEC [8] = '{
      {3'd0, 1'b0, 8'h41}, {3'd1, 1'b0, 8'h7E}, {3'd2, 1'b0, 8'h33},
      {3'd3, 1'b1, 8'h15}, {3'd4, 1'b0, 8'hA5}, {3'd5, 1'b0, 8'h80},
      {3'd6, 1'b1, 8'hC3}, {3'd7, 1'b0, 8'h5B}};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; #1 v = rdata;
   endtask

   task automatic rd_take(output logic [7:0] v);
      @(negedge clk); addr = 3'd4; rd_en = 1'b1; #1 v = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   function automatic logic [12:0] mk(input logic [2:0] md, input logic odd,
         input logic mpe, input logic mpb, input logic [7:0] d, output int n);
      logic [12:0] f;
      logic [7:0] dm;
      int p;
      f = '1; f[0] = 1'b0; p = 1;
      dm = md[2] ? d : {1'b0, d[6:0]};
      for (int i = 0; i < (md[2] ? 8 : 7); i++) begin f[p] = d[i]; p++; end
      if (mpe) begin f[p] = mpb; p++; end
      if (md[1]) begin f[p] = (^dm) ^ odd; p++; end
      p += md[0] ? 2 : 1;
      n = p;
      return f;
   endfunction

   task automatic capture(input int n, input int bitc, output logic [12:0] bits);
      int w = 0;
      bits = '1;
      while (txd !== 1'b0 && w < 30000) begin @(negedge clk); w++; end
      repeat (bitc / 2) @(negedge clk);
      for (int i = 0; i < n; i++) begin
         bits[i] = txd;
         repeat (bitc) @(negedge clk);
      end
   endtask

   task automatic measure_low(output int c);
      int w = 0;
      c = 0;
      while (txd !== 1'b0 && w < 30000) begin @(negedge clk); w++; end
      while (txd === 1'b0 && c < 30000) begin @(negedge clk); c++; end
   endtask

   task automatic send(input logic [12:0] bits, input int n, input int bitc);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); rxd = bits[i];
         repeat (bitc - 1) @(negedge clk);
      end
      @(negedge clk); rxd = 1'b1;
      repeat (bitc) @(negedge clk);
   endtask

   initial begin
      logic [7:0] v;
      logic [12:0] f, got;
      int n, c;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R13: reset state
      rd(3'd0, v); check("R13 ctl_a", v, 8'h10);
      rd(3'd1, v); check("R13 ctl_b", v, 8'h00);
      rd(3'd2, v); check("R13 status", v, 8'h02);
      check("R13 txd/irq", {txd, rx_irq, tx_irq, rts_n}, 4'b1001);

      // R1 R4 R5 R6: every format through transmitter and receiver
      for (int k = 0; k < 8; k++) begin
         logic [2:0] md;
         logic odd;
         logic [7:0] d;
         md = VEC[k][11:9]; odd = VEC[k][8]; d = VEC[k][7:0];
         wr(3'd1, {3'b000, odd, 4'b0000});
         wr(3'd0, {5'b01111, md});
         wr(3'd3, d);
         f = mk(md, odd, 1'b0, 1'b0, d, n);
         capture(n, 160, got);
         check("R1 R4 tx frame", got, f);
         rd(3'd2, v); check("R5 tx empty", v[1], 1'b1);
         send(f, n, 160);
         rd(3'd2, v); check("R6 rx full, no errors", v[7:4], 4'b1000);
         rd_take(v); check("R6 rx data", v, md[2] ? d : {1'b0, d[6:0]});
         rd(3'd2, v); check("R6 full cleared", v[7], 1'b0);
      end

      // R2: bit period under each divider choice (mode 0, data 0: 8 low bits)
      wr(3'd0, 8'h78);
      wr(3'd1, 8'h21); wr(3'd3, 8'h00); measure_low(c);
      check("R2 P=30 S=16 SS=1", c, 8 * 960);
      repeat (1200) @(negedge clk);
      wr(3'd1, 8'h08); wr(3'd3, 8'h00); measure_low(c);
      check("R2 P=10 S=64 SS=0", c, 8 * 640);
      repeat (800) @(negedge clk);
      // R3: external clock, 100-cycle period, 16 edges per bit
      wr(3'd1, 8'h07); wr(3'd3, 8'h00); measure_low(c);
      check("R3 external clock", c, 8 * 1600);
      repeat (2000) @(negedge clk);

      // R5: clear-to-send holds the transmitter
      wr(3'd1, 8'h00); wr(3'd0, 8'h7C);
      cts_n = 1'b1;
      wr(3'd3, 8'h12);
      repeat (800) @(negedge clk);
      rd(3'd2, v);
      check("R5 held by cts", {txd, v[1]}, 2'b10);
      cts_n = 1'b0;
      f = mk(3'd4, 1'b0, 1'b0, 1'b0, 8'h12, n);
      capture(n, 160, got); check("R5 sent after cts", got, f);
      // R11: transmit interrupt
      wr(3'd2, 8'h01); check("R11 tx_irq", tx_irq, 1'b1);
      wr(3'd2, 8'h08); check("R11 rx_irq idle", rx_irq, 1'b0);

      // R7: overrun keeps first character
      f = mk(3'd4, 1'b0, 1'b0, 1'b0, 8'h11, n); send(f, n, 160);
      check("R11 rx_irq full", rx_irq, 1'b1);
      f = mk(3'd4, 1'b0, 1'b0, 1'b0, 8'h22, n); send(f, n, 160);
      rd(3'd2, v); check("R7 overrun", v[7:6], 2'b11);
      rd_take(v); check("R7 first kept", v, 8'h11);
      // R6: parity error, then framing error
      wr(3'd0, 8'h7E);
      f = mk(3'd6, 1'b0, 1'b0, 1'b0, 8'h0F, n); f[9] = ~f[9]; send(f, n, 160);
      rd(3'd2, v); check("R6 parity error", v[5], 1'b1);
      rd_take(v);
      wr(3'd0, 8'h7C);
      f = mk(3'd4, 1'b0, 1'b0, 1'b0, 8'h3C, n); f[9] = 1'b0; send(f, n, 160);
      rd(3'd2, v); check("R6 framing error", v[7:4], 4'b1111);
      // R8: clear errors, full stays
      wr(3'd0, 8'h74);
      rd(3'd2, v); check("R8 error clear", v[7:4], 4'b1000);
      rd_take(v);

      // R10: short low pulse is no character
      @(negedge clk); rxd = 1'b0; repeat (40) @(negedge clk); rxd = 1'b1;
      repeat (2000) @(negedge clk);
      rd(3'd2, v); check("R10 glitch rejected", v[7], 1'b0);

      // R12: carrier detect gates the receiver, rts follows control
      dcd_n = 1'b1;
      rd(3'd2, v); check("R12 dcd reflected", v[2], 1'b1);
      f = mk(3'd4, 1'b0, 1'b0, 1'b0, 8'h66, n); send(f, n, 160);
      rd(3'd2, v); check("R12 no rx without dcd", v[7], 1'b0);
      dcd_n = 1'b0;
      wr(3'd0, 8'h6C); check("R12 rts low", rts_n, 1'b0);

      // R9: multiprocessor bit on transmit and receive
      wr(3'd1, 8'h80); wr(3'd0, 8'hFC);
      wr(3'd3, 8'h5A);
      f = mk(3'd4, 1'b0, 1'b1, 1'b1, 8'h5A, n);
      capture(n, 160, got); check("R9 tx mp bit", got, f);
      f = mk(3'd4, 1'b0, 1'b1, 1'b0, 8'h77, n); send(f, n, 160);
      rd(3'd2, v); check("R9 mp=0 discarded", v[7:4], 4'b0000);
      f = mk(3'd4, 1'b0, 1'b1, 1'b1, 8'h3C, n); send(f, n, 160);
      rd(3'd0, v); check("R9 mp bit read back", v[3], 1'b1);
      rd_take(v); check("R9 mp=1 accepted", v, 8'h3C);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule